// File: doc/BRIEF.md
# Dot-Matrix Display Register File

This block is the host-facing storage of an eight-digit dot-matrix display controller. A host drives an asynchronous strobe bus (active-low chip enable, write, read and a flash-area select, plus a five-bit address and an eight-bit data bus). The block brings those strobes into the display clock domain and writes or reads one of five areas: per-digit character codes, per-digit flash bits, a user-glyph index register, a table of user glyph patterns, and a control word. Read data leaves on a data output with a separate output enable, ready to feed a tristate pad.

The refresh logic reads the same storage through independent ports. It supplies a digit number and a glyph row. It gets back that digit's character code and flash bit, and it gets the user glyph row when the code selects a user glyph. Reset blanks the text, and writing the clear bit of the control word blanks it again. While reset recovery, a clear or an external self test is in progress, a busy output is high and host writes are dropped.

Top module: `mdr_top`

## Requirements
- R1: With `bus_fl_n` low, the flash area is selected whatever `bus_addr[4:3]` hold. `bus_addr[2:0]` picks the digit, a write stores only `bus_din[0]`, and a read returns the bit in bit 0 with bits 7..1 zero.
- R2: With `bus_fl_n` high, `bus_addr[4:3]` select the area: 2'b00 is the glyph index, 2'b01 is a glyph row, 2'b10 is the control word and 2'b11 is the character store.
- R3: A write is stored only when `bus_wr_n` rises while `bus_ce_n` is low. A write strobe given with `bus_ce_n` high changes nothing.
- R4: `bus_doe` is 1 while both `bus_ce_n` and `bus_rd_n` are held low, and 0 otherwise.
- R5: The glyph index register keeps `bus_din[3:0]` and ignores bits 7..4. A read returns it with bits 7..4 zero.
- R6: A glyph row write stores `bus_din[4:0]` into row `bus_addr[2:0]` of the glyph chosen by the index register. Rows 0..6 exist. A write to row 7 is ignored and a read of row 7 returns zero.
- R7: A character write stores all eight bits of digit `bus_addr[2:0]`. On the refresh port, `rf_char` and `rf_flash` return the entry for `rf_digit`. `rf_udc_pat` returns row `rf_row` of glyph `rf_char[3:0]` when `rf_char[7]` is 1, and zero when bit 7 is 0 or the row is 7.
- R8: Reset sets every character to 8'h20 and clears the flash bits and the control word. The glyph index register and glyph rows keep their contents.
- R9: `busy` is high from reset for three clock cycles after reset is released and then falls.
- R10: Writing control bit 7 as 1 sets every character to 8'h20 and every flash bit to 0 within three cycles. Bit 7 then returns to 0, and control bits 6..0 keep their written values.
- R11: Control bit 5 reads back `st_pass` and cannot be written. A control write with bit 6 set gives a single one-cycle pulse on `st_start`, and bit 6 reads back as written.
- R12: While `st_active` is high, `busy` is high and host writes are dropped.
- R13: `cw_bright` shows control bits 2..0, `cw_flash_en` shows bit 3 and `cw_blink_en` shows bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_wr_n | input | 1 | Write strobe, active low, commits on its rising edge |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_fl_n | input | 1 | Flash-area select, active low |
| bus_addr | input | 5 | Area select [4:3] and location [2:0] |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data |
| bus_doe | output | 1 | Read data output enable |
| busy | output | 1 | Recovery, clear or self test in progress |
| st_start | output | 1 | One-cycle self-test start pulse |
| st_active | input | 1 | External self test running |
| st_pass | input | 1 | External self-test result |
| rf_digit | input | 3 | Refresh digit select |
| rf_row | input | 3 | Refresh glyph row select |
| rf_char | output | 8 | Character code of the refresh digit |
| rf_flash | output | 1 | Flash bit of the refresh digit |
| rf_udc_pat | output | 5 | User glyph row for the refresh digit |
| cw_bright | output | 3 | Brightness code |
| cw_flash_en | output | 1 | Per-digit flashing enabled |
| cw_blink_en | output | 1 | Whole-display blinking enabled |

## Verification
The bench targets the priority of the flash select over the area bits. A decoder that honoured `bus_addr[4:3]` first would overwrite a character or the control word instead of a flash bit. It writes glyph rows after moving the index, so a design that latched the index into the row address would hit the wrong glyph. It also writes row 7, which would alias onto a real row if left unguarded. It resets after loading glyphs to catch a reset that wipes glyph storage. It writes the clear bit together with other control bits to catch a clear that erases brightness, blink or flash enable, or that never drops bit 7. It gives strobes with chip enable high and during an external self test to catch writes that slip through.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
   typedef enum logic [1:0] {
      SEC_IDX = 2'b00,
      SEC_UDC = 2'b01,
      SEC_CTL = 2'b10,
      SEC_CHR = 2'b11
   } sec_e;

   localparam logic [7:0] CH_BLANK = 8'h20;
   localparam int CW_CLR = 7;
   localparam int CW_ST  = 6;
   localparam int CW_RES = 5;
   localparam int CW_BLK = 4;
   localparam int CW_FLS = 3;
endpackage

// File: rtl/mdr_sync.sv
module mdr_sync #(
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("mdr_sync: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= RST_VAL;
         q      <= RST_VAL;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/mdr_seq.sv
module mdr_seq #(
   parameter int RECOV_CYC = 3,
   parameter int CLR_CYC   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_go,
   input  logic st_active,
   output logic busy,
   output logic clr_fire
);
   localparam int MAXC  = (RECOV_CYC > CLR_CYC) ? RECOV_CYC : CLR_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);

   generate
      if (CLR_CYC < 1 || RECOV_CYC < 1) begin : g_bad_cyc
         $error("mdr_seq: cycle counts must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;

   assign clr_fire = pend_q && (cnt_q == CNT_W'(1));
   assign busy     = (cnt_q != '0) || st_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(RECOV_CYC);
         pend_q <= 1'b0;
      end else if (clr_go) begin
         cnt_q  <= CNT_W'(CLR_CYC);
         pend_q <= 1'b1;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         if (clr_fire)    pend_q <= 1'b0;
      end
   end

   AST_PEND_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q != '0)); // R10
   AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_go |=> busy); // R10
endmodule

// File: rtl/mdr_top.sv
module mdr_top #(
   parameter int DIGITS    = 8,
   parameter int UDC_N     = 16,
   parameter int UDC_ROWS  = 7,
   parameter int UDC_COLS  = 5,
   parameter int RECOV_CYC = 3,
   parameter int CLR_CYC   = 3,
   parameter bit RD_REG    = 1'b1,
   localparam int DIG_W    = $clog2(DIGITS),
   localparam int IDX_W    = $clog2(UDC_N),
   localparam int ROW_W    = $clog2(UDC_ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_ce_n,
   input  logic                bus_wr_n,
   input  logic                bus_rd_n,
   input  logic                bus_fl_n,
   input  logic [4:0]          bus_addr,
   input  logic [7:0]          bus_din,
   output logic [7:0]          bus_dout,
   output logic                bus_doe,
   output logic                busy,
   output logic                st_start,
   input  logic                st_active,
   input  logic                st_pass,
   input  logic [DIG_W-1:0]    rf_digit,
   input  logic [2:0]          rf_row,
   output logic [7:0]          rf_char,
   output logic                rf_flash,
   output logic [UDC_COLS-1:0] rf_udc_pat,
   output logic [2:0]          cw_bright,
   output logic                cw_flash_en,
   output logic                cw_blink_en
);
   import mdr_pkg::*;

   generate
      if (DIGITS < 2 || DIGITS > 8) begin : g_bad_dig
         $error("mdr_top: DIGITS must be 2..8");
      end
      if (UDC_N < 2 || UDC_N > 16) begin : g_bad_udc
         $error("mdr_top: UDC_N must be 2..16");
      end
      if (UDC_ROWS < 2 || UDC_ROWS > 8 || UDC_COLS < 1 || UDC_COLS > 8) begin : g_bad_geo
         $error("mdr_top: glyph geometry out of range");
      end
   endgenerate

   // strobe synchronisation and write capture
   logic ce_s, wr_s, rd_s, ce_d, wr_d;
   mdr_sync #(.W(3), .RST_VAL(3'b111)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({bus_ce_n, bus_wr_n, bus_rd_n}),
      .q({ce_s, wr_s, rd_s})
   );

   logic       wq_vld, wq_fl;
   logic [4:0] wq_addr;
   logic [7:0] wq_data;
   logic       wr_edge;
   assign wr_edge = wr_s && !wr_d && !ce_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_d    <= 1'b1;
         wr_d    <= 1'b1;
         wq_vld  <= 1'b0;
         wq_fl   <= 1'b1;
         wq_addr <= '0;
         wq_data <= '0;
      end else begin
         ce_d   <= ce_s;
         wr_d   <= wr_s;
         wq_vld <= wr_edge;
         if (wr_edge) begin
            wq_fl   <= bus_fl_n;
            wq_addr <= bus_addr;
            wq_data <= bus_din;
         end
      end
   end

   // sequencer
   logic clr_go, clr_fire;
   mdr_seq #(.RECOV_CYC(RECOV_CYC), .CLR_CYC(CLR_CYC)) i_seq (
      .clk(clk), .rst_n(rst_n), .clr_go(clr_go), .st_active(st_active),
      .busy(busy), .clr_fire(clr_fire)
   );

   // write decode
   logic commit, wr_fla, wr_idx, wr_udc, wr_ctl, wr_chr, w_dig_ok, w_row_ok;
   sec_e w_sec;
   assign commit   = wq_vld && !busy;
   assign w_sec    = sec_e'(wq_addr[4:3]);
   assign w_dig_ok = ({1'b0, wq_addr[2:0]} < 4'(DIGITS));
   assign w_row_ok = ({1'b0, wq_addr[2:0]} < 4'(UDC_ROWS));
   assign wr_fla   = commit && !wq_fl && w_dig_ok;
   assign wr_idx   = commit && wq_fl && (w_sec == SEC_IDX);
   assign wr_udc   = commit && wq_fl && (w_sec == SEC_UDC) && w_row_ok;
   assign wr_ctl   = commit && wq_fl && (w_sec == SEC_CTL);
   assign wr_chr   = commit && wq_fl && (w_sec == SEC_CHR) && w_dig_ok;
   assign clr_go   = wr_ctl && wq_data[CW_CLR];

   // storage
   logic [7:0]          char_q [DIGITS];
   logic [DIGITS-1:0]   flash_q;
   logic [7:0]          ctl_q;
   logic [IDX_W-1:0]    udc_idx_q;
   logic [UDC_COLS-1:0] udc_q [UDC_N][UDC_ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DIGITS; i++) char_q[i] <= CH_BLANK;
         flash_q  <= '0;
         ctl_q    <= '0;
         st_start <= 1'b0;
      end else begin
         st_start <= wr_ctl && wq_data[CW_ST];
         if (clr_fire) begin
            for (int i = 0; i < DIGITS; i++) char_q[i] <= CH_BLANK;
            flash_q       <= '0;
            ctl_q[CW_CLR] <= 1'b0;
         end else begin
            if (wr_chr) char_q[wq_addr[DIG_W-1:0]] <= wq_data;
            if (wr_fla) flash_q[wq_addr[DIG_W-1:0]] <= wq_data[0];
            if (wr_ctl) ctl_q <= {wq_data[7:6], 1'b0, wq_data[4:0]};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_idx) udc_idx_q <= wq_data[IDX_W-1:0];
      if (wr_udc) udc_q[udc_idx_q][wq_addr[ROW_W-1:0]] <= wq_data[UDC_COLS-1:0];
   end

   // host read path
   logic [7:0] rd_data;
   logic       r_dig_ok, r_row_ok;
   assign r_dig_ok = ({1'b0, bus_addr[2:0]} < 4'(DIGITS));
   assign r_row_ok = ({1'b0, bus_addr[2:0]} < 4'(UDC_ROWS));

   always_comb begin
      rd_data = '0;
      if (!bus_fl_n) begin
         rd_data[0] = r_dig_ok ? flash_q[bus_addr[DIG_W-1:0]] : 1'b0;
      end else begin
         unique case (sec_e'(bus_addr[4:3]))
            SEC_IDX: rd_data = 8'(udc_idx_q);
            SEC_UDC: rd_data = r_row_ok ? 8'(udc_q[udc_idx_q][bus_addr[ROW_W-1:0]]) : 8'h00;
            SEC_CTL: rd_data = {ctl_q[7:6], st_pass, ctl_q[4:0]};
            SEC_CHR: rd_data = r_dig_ok ? char_q[bus_addr[DIG_W-1:0]] : 8'h00;
            default: rd_data = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_doe <= 1'b0;
      else        bus_doe <= !ce_s && !rd_s;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bus_dout <= '0;
            else        bus_dout <= rd_data;
         end
      end else begin : g_rd_comb
         assign bus_dout = rd_data;
      end
   endgenerate

   // refresh and control outputs
   logic rf_row_ok;
   assign rf_row_ok   = ({1'b0, rf_row} < 4'(UDC_ROWS));
   assign rf_char     = char_q[rf_digit];
   assign rf_flash    = flash_q[rf_digit];
   assign rf_udc_pat  = (rf_char[7] && rf_row_ok) ?
                        udc_q[rf_char[IDX_W-1:0]][rf_row[ROW_W-1:0]] : '0;
   assign cw_bright   = ctl_q[2:0];
   assign cw_flash_en = ctl_q[CW_FLS];
   assign cw_blink_en = ctl_q[CW_BLK];

   AST_CLR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire |=> (char_q[0] == CH_BLANK && char_q[DIGITS-1] == CH_BLANK
                    && flash_q == '0 && !ctl_q[CW_CLR])); // R10
   AST_CLR_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire |=> (ctl_q[6:0] == $past(ctl_q[6:0]))); // R10
   AST_BUSY_FREEZES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(udc_idx_q)); // R12
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      st_start |=> !st_start); // R11
   AST_RES_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> !ctl_q[CW_RES]); // R11
endmodule

// File: tb/test_mdr_top.sv
module test_mdr_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, ce_n, wr_n, rd_n, fl_n, st_active, st_pass;
   logic [4:0] addr;
   logic [7:0] din, dout, rf_char;
   logic       doe, busy, st_start, rf_flash, cw_flash_en, cw_blink_en;
   logic [2:0] rf_digit, rf_row, cw_bright;
   logic [4:0] rf_udc_pat;

   mdr_top i_mdr_top (
      .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
      .bus_fl_n(fl_n), .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
      .busy(busy), .st_start(st_start), .st_active(st_active), .st_pass(st_pass),
      .rf_digit(rf_digit), .rf_row(rf_row), .rf_char(rf_char), .rf_flash(rf_flash),
      .rf_udc_pat(rf_udc_pat), .cw_bright(cw_bright), .cw_flash_en(cw_flash_en),
      .cw_blink_en(cw_blink_en)
   );

   int checks = 0, fails = 0, pulses = 0;
   bit done = 1'b0;

   logic [7:0] m_char [8];
   logic [7:0] m_flash;
   logic [7:0] m_ctl;
   logic [3:0] m_idx;
   logic [4:0] m_udc [16][7];

   always @(posedge clk) if (st_start) pulses++;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic fl, input logic [4:0] a);
      if (!fl) return {7'b0, m_flash[a[2:0]]};
      case (a[4:3])
         2'b00:   return {4'b0, m_idx};
         2'b01:   return (a[2:0] == 3'd7) ? 8'h00 : {3'b0, m_udc[m_idx][a[2:0]]};
         2'b10:   return {m_ctl[7:6], st_pass, m_ctl[4:0]};
         default: return m_char[a[2:0]];
      endcase
   endfunction

   task automatic mdl_wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
      if (!fl) m_flash[a[2:0]] = d[0];
      else case (a[4:3])
         2'b00: m_idx = d[3:0];
         2'b01: if (a[2:0] != 3'd7) m_udc[m_idx][a[2:0]] = d[4:0];
         2'b10: m_ctl = {d[7:6], 1'b0, d[4:0]};
         default: m_char[a[2:0]] = d;
      endcase
   endtask

   task automatic bus_wr(input logic fl, input logic [4:0] a, input logic [7:0] d,
                         input logic use_ce);
      @(negedge clk);
      fl_n = fl; addr = a; din = d; ce_n = !use_ce;
      repeat (2) @(negedge clk);
      wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
      bus_wr(fl, a, d, 1'b1);
      mdl_wr(fl, a, d);
   endtask

   task automatic bus_rd(input logic fl, input logic [4:0] a,
                         output logic [7:0] d, output logic oe);
      @(negedge clk);
      fl_n = fl; addr = a; ce_n = 1'b0; rd_n = 1'b0;
      repeat (6) @(negedge clk);
      d = dout; oe = doe;
      rd_n = 1'b1; ce_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic fl, input logic [4:0] a);
      logic [7:0] d;
      logic oe;
      bus_rd(fl, a, d, oe);
      chk(req, d, exp_rd(fl, a));
      chk({req, " oe"}, {7'b0, oe}, 8'h01);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) m_char[i] = 8'h20;
      m_flash = '0;
      m_ctl = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic oe;
      int unused_seed;
      unused_seed = $urandom(32'd4711);
      ce_n = 1; wr_n = 1; rd_n = 1; fl_n = 1; addr = '0; din = '0;
      st_active = 0; st_pass = 1; rf_digit = '0; rf_row = '0;
      do_reset();
      chk("R9 busy after release", {7'b0, busy}, 8'h01);
      repeat (5) @(negedge clk);
      chk("R9 busy falls", {7'b0, busy}, 8'h00);
      chk("R4 doe idle", {7'b0, doe}, 8'h00);
      for (int i = 0; i < 8; i++) rd_chk("R8 reset char", 1'b1, {2'b11, 3'(i)});
      rd_chk("R8 reset ctl", 1'b1, 5'b10000);

      // load all glyph rows, moving the index each time
      for (int g = 0; g < 16; g++) begin
         wr(1'b1, 5'b00000, {4'hA, 4'(g)});
         for (int r = 0; r < 7; r++) wr(1'b1, {2'b01, 3'(r)}, 8'($urandom));
      end
      rd_chk("R5 index upper ignored", 1'b1, 5'b00000);
      wr(1'b1, 5'b00000, 8'h05);
      wr(1'b1, 5'b01111, 8'h1F);
      rd_chk("R6 row7 ignored", 1'b1, 5'b01111);
      rd_chk("R6 row0", 1'b1, 5'b01000);

      // flash select overrides area bits
      wr(1'b1, 5'b11011, 8'h41);
      wr(1'b1, 5'b10000, 8'h05);
      wr(1'b0, 5'b11011, 8'hFF);
      rd_chk("R1 flash bit", 1'b0, 5'b00011);
      rd_chk("R1 char untouched", 1'b1, 5'b11011);
      rd_chk("R2 ctl untouched", 1'b1, 5'b10000);

      // strobe with CE high
      bus_wr(1'b1, 5'b11011, 8'h7E, 1'b0);
      rd_chk("R3 ce high ignored", 1'b1, 5'b11011);
      @(negedge clk); fl_n = 1; addr = 5'b11011; ce_n = 1; rd_n = 0;
      repeat (6) @(negedge clk);
      chk("R4 rd without ce", {7'b0, doe}, 8'h00);
      rd_n = 1; repeat (3) @(negedge clk);

      // random phase
      for (int n = 0; n < 150; n++) begin
         logic fl;
         logic [4:0] a;
         logic [7:0] dd;
         fl = ($urandom % 5) != 0;
         a = 5'($urandom);
         dd = 8'($urandom);
         if (fl && a[4:3] == 2'b10) dd[7:6] = 2'b00;
         if (($urandom % 2) == 0) wr(fl, a, dd);
         else rd_chk("R2 random read", fl, a);
      end

      // user glyph shown through the refresh port
      wr(1'b1, 5'b00000, 8'h05);
      wr(1'b1, 5'b01010, 8'h11);
      wr(1'b1, 5'b11010, 8'h85);
      for (int dg = 0; dg < 8; dg++) begin
         for (int r = 0; r < 8; r++) begin
            logic [4:0] ep;
            @(negedge clk); rf_digit = 3'(dg); rf_row = 3'(r); #1;
            ep = (m_char[dg][7] && r < 7) ? m_udc[m_char[dg][3:0]][r] : 5'h00;
            chk("R7 rf_udc_pat", {3'b0, rf_udc_pat}, {3'b0, ep});
            if (r == 0) begin
               chk("R7 rf_char", rf_char, m_char[dg]);
               chk("R7 rf_flash", {7'b0, rf_flash}, {7'b0, m_flash[dg]});
            end
         end
      end

      // self-test start and result bit
      begin
         int p0;
         p0 = pulses;
         wr(1'b1, 5'b10000, 8'h60);
         chk("R11 one start pulse", 8'(pulses - p0), 8'h01);
         st_pass = 0;
         rd_chk("R11 result fail", 1'b1, 5'b10000);
         st_pass = 1;
         rd_chk("R11 result pass", 1'b1, 5'b10000);
      end

      // self test active drops writes
      @(negedge clk); st_active = 1; @(negedge clk);
      chk("R12 busy in test", {7'b0, busy}, 8'h01);
      bus_wr(1'b1, 5'b11000, 8'h3C, 1'b1);
      bus_wr(1'b1, 5'b00000, 8'h09, 1'b1);
      st_active = 0;
      rd_chk("R12 char kept", 1'b1, 5'b11000);
      rd_chk("R12 index kept", 1'b1, 5'b00000);

      // clear keeps the other control bits
      wr(1'b0, 5'b00010, 8'h01);
      wr(1'b1, 5'b10000, 8'h9B);
      m_ctl = 8'h1B;
      for (int i = 0; i < 8; i++) m_char[i] = 8'h20;
      m_flash = '0;
      rd_chk("R10 ctl after clear", 1'b1, 5'b10000);
      rd_chk("R10 char blank", 1'b1, 5'b11010);
      rd_chk("R10 flash clear", 1'b0, 5'b00010);
      chk("R13 brightness", {5'b0, cw_bright}, 8'h03);
      chk("R13 flash enable", {7'b0, cw_flash_en}, 8'h01);
      chk("R13 blink enable", {7'b0, cw_blink_en}, 8'h01);

      // reset keeps glyph storage
      wr(1'b1, 5'b11001, 8'h4D);
      do_reset();
      repeat (6) @(negedge clk);
      rd_chk("R8 char reset", 1'b1, 5'b11001);
      rd_chk("R8 index kept", 1'b1, 5'b00000);
      rd_chk("R8 glyph kept", 1'b1, 5'b01010);
      rd_chk("R8 ctl reset", 1'b1, 5'b10000);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule